// File: doc/BRIEF.md
# Controller Interrupt Status Aggregator

This block holds the status and interrupt registers of a network controller. A main status/control register carries the run-state flags (stopped, started, initialised, transmitter on, receiver on) and six event flags raised by the transmit, receive and init engines. Two auxiliary status registers carry further event flags, each paired with an enable bit. A mask register suppresses selected main-register events. Every cycle the block forms a summary interrupt flag from all four registers. That flag reads back as bit 7 of the main register, and it drives the interrupt line when the interrupt-enable input is high.

Software accesses the registers through a single port. The port has a 2-bit address, 16-bit write data and a write strobe. The read data is a combinational view of the addressed register. Event bits are write-one-to-clear. When an engine pulse and a clearing write hit the same bit in the same cycle, the pulse wins. The run state is tracked by a three-state machine. ST_HALT is the reset state, with the stop bit set. ST_READY follows initialisation. ST_ACTIVE follows a start command. The transitions are:
- ST_HALT→ST_READY on init done.
- ST_HALT→ST_ACTIVE or ST_READY→ST_ACTIVE on a start write.
- ST_READY→ST_HALT or ST_ACTIVE→ST_HALT on a stop write.

Top module: `isr_aggregator`

## Requirements
- R1: After reset the main register reads 0x0004 (stop bit only), the auxiliary and mask registers read 0x0000 and the interrupt line is low.
- R2: Engine pulses set main-register event bits at these positions: init-done bit 8, transmit bit 9, receive bit 10, memory-error bit 11, missed-frame bit 12 and babble bit 14. Writing 1 to one of these bits at address 0 clears it. Writing 0 leaves it unchanged.
- R3: Main bit 7 reads 1 whenever (main & ~mask) & 0x5F00 is nonzero, where the mask register sits at address 3. It is recomputed from the current register contents in every cycle.
- R4: Main bit 7 is also 1 when ((aux1 >> 1) & ~aux1) & 0x0115 is nonzero. In aux1 (address 1), event bits 1, 3, 5 and 9 each count only while the bit just below them is 0.
- R5: Main bit 7 is also 1 when aux2 (address 2) has bits 3 and 4 both set.
- R6: The interrupt line is high exactly when the summary condition holds and the interrupt-enable input is high.
- R7: When aux1 bit 7 (user request) is 1 and interrupt-enable is high, the next clock clears bit 7 and sets bit 6.
- R8: In aux1, writing 1 clears a bit in 0x026A. In aux2, writing 1 clears a bit in 0x0A90. All other bits of those registers, and all mask bits, take the written value.
- R9: An init-done pulse sets main bits 0 and 8 and clears the stop bit (bit 2).
- R10: Writing 1 to main bit 1 while not started sets bit 1 and clears bit 2. It also sets bit 4 unless the transmit-disable input is high, and sets bit 5 unless the receive-disable input is high. While already started, such a write is ignored.
- R11: Writing 1 to main bit 2 sets the stop bit and clears bits 0, 1, 4 and 5. Event bits are kept. Stop takes precedence over a start in the same write.
- R12: An engine pulse and a write-one-to-clear on the same bit in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 main, 1 aux1, 2 aux2, 3 mask |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| int_en | input | 1 | Interrupt enable |
| tx_off | input | 1 | Transmit disabled; start leaves transmit-on clear |
| rx_off | input | 1 | Receive disabled; start leaves receive-on clear |
| init_done | input | 1 | Init engine completion pulse |
| ev_tx | input | 1 | Transmit completion pulse |
| ev_rx | input | 1 | Receive completion pulse |
| ev_merr | input | 1 | Memory error pulse |
| ev_miss | input | 1 | Missed frame pulse |
| ev_babl | input | 1 | Babble pulse |
| ev_aux1 | input | 4 | Aux1 event pulses for bits 1, 3, 5, 9 |
| ev_aux2 | input | 1 | Aux2 event pulse for bit 4 |
| reg_rdata | output | 16 | Read data of the addressed register |
| intr | output | 1 | Interrupt line |

## Verification
Several rules are checked by assertions on every cycle:
- Pulse-over-clear priority, and the clearing of write-one-to-clear bits.
- The run-state effects of start, stop and init done.
- The user-request conversion.

Only the bench scenarios can show the following:
- The value of the summary flag under each of the three condition paths, and under masking.
- The mixed write-to-clear and plain-bit layout seen through read data.
- That a repeated start is ignored.
- That the disable inputs gate the transmit-on and receive-on flags.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int DW = 16;
    localparam int AW = 2;

    localparam logic [AW-1:0] A_MAIN = 2'd0;
    localparam logic [AW-1:0] A_AUX1 = 2'd1;
    localparam logic [AW-1:0] A_AUX2 = 2'd2;
    localparam logic [AW-1:0] A_MASK = 2'd3;

    localparam logic [DW-1:0] MAIN_EVT_BITS = 16'h5F00;
    localparam logic [DW-1:0] AUX1_W1C      = 16'h026A;
    localparam logic [DW-1:0] AUX2_W1C      = 16'h0A90;
    localparam logic [DW-1:0] AUX1_PAIRS    = 16'h0115;

    localparam int N_AUX1_EVT = 4;
    localparam int AUX1_EVT_POS [N_AUX1_EVT] = '{1, 3, 5, 9};
    localparam int AUX2_EVT_POS = 4;
    localparam int UREQ_BIT  = 7;
    localparam int USTAT_BIT = 6;
    localparam int SUM_BIT   = 7;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_READY  = 2'd1,
        ST_ACTIVE = 2'd2
    } run_state_t;
endpackage

// File: rtl/isr_flag_reg.sv
module isr_flag_reg
    import isr_pkg::*;
#(
    parameter int              W        = DW,
    parameter logic [W-1:0]    W1C_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (W1C_MASK[i]) begin : g_w1c
            always_ff @(posedge clk) begin
                if (!rst_n)            q[i] <= 1'b0;
                else if (hw_set[i])    q[i] <= 1'b1;
                else if (hw_clr[i])    q[i] <= 1'b0;
                else if (wr && wdata[i]) q[i] <= 1'b0;
            end

            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && wdata[i] && !hw_set[i]) |=> !q[i]); // R8
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)         q[i] <= 1'b0;
                else if (hw_set[i]) q[i] <= 1'b1;
                else if (wr)        q[i] <= wdata[i];
                else if (hw_clr[i]) q[i] <= 1'b0;
            end
        end

        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> q[i]); // R12
    end
endmodule

// File: rtl/isr_ctl_fsm.sv
module isr_ctl_fsm
    import isr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       init_done,
    input  logic       tx_off,
    input  logic       rx_off,
    output logic [5:0] ctl
);
    run_state_t state, state_nx;
    logic init_q, txon_q, rxon_q;
    logic start_ok;

    assign start_ok = start_req && !stop_req && (state != ST_ACTIVE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: begin
                if (stop_req)       state_nx = ST_HALT;
                else if (start_req) state_nx = ST_ACTIVE;
                else if (init_done) state_nx = ST_READY;
            end
            ST_READY: begin
                if (stop_req)       state_nx = ST_HALT;
                else if (start_req) state_nx = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (stop_req)       state_nx = ST_HALT;
            end
            default: state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HALT;
            init_q <= 1'b0;
            txon_q <= 1'b0;
            rxon_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (stop_req) begin
                init_q <= 1'b0;
                txon_q <= 1'b0;
                rxon_q <= 1'b0;
            end else begin
                if (init_done) init_q <= 1'b1;
                if (start_ok) begin
                    txon_q <= !tx_off;
                    rxon_q <= !rx_off;
                end
            end
        end
    end

    always_comb begin
        ctl    = '0;
        ctl[0] = init_q;
        ctl[1] = (state == ST_ACTIVE);
        ctl[2] = (state == ST_HALT);
        ctl[4] = txon_q;
        ctl[5] = rxon_q;
    end

    AST_START_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !stop_req) |=> (ctl[1] && !ctl[2])); // R10
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (ctl[2] && !ctl[1] && !ctl[4] && !ctl[5] && !ctl[0])); // R11
    AST_INIT_LEAVES_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !stop_req) |=> (ctl[0] && !ctl[2])); // R9
endmodule

// File: rtl/isr_summary.sv
module isr_summary
    import isr_pkg::*;
(
    input  logic [DW-1:0] main_evt,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] aux1,
    input  logic [DW-1:0] aux2,
    output logic          summary
);
    logic hit_main, hit_aux1, hit_aux2;

    always_comb begin
        hit_main = |(main_evt & ~mask & MAIN_EVT_BITS);
        hit_aux1 = |((aux1 >> 1) & ~aux1 & AUX1_PAIRS);
        hit_aux2 = aux2[3] & aux2[4];
        summary  = hit_main | hit_aux1 | hit_aux2;
    end
endmodule

// File: rtl/isr_aggregator.sv
module isr_aggregator
    import isr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    input  logic          reg_wr,
    input  logic          int_en,
    input  logic          tx_off,
    input  logic          rx_off,
    input  logic          init_done,
    input  logic          ev_tx,
    input  logic          ev_rx,
    input  logic          ev_merr,
    input  logic          ev_miss,
    input  logic          ev_babl,
    input  logic [3:0]    ev_aux1,
    input  logic          ev_aux2,
    output logic [15:0]   reg_rdata,
    output logic          intr
);
    logic wr_main, wr_aux1, wr_aux2, wr_mask;
    logic [DW-1:0] evt_q, aux1_q, aux2_q, mask_q;
    logic [DW-1:0] evt_set, aux1_set, aux1_clr, aux2_set;
    logic [5:0]    ctl;
    logic          summary;
    logic          uconv;

    assign wr_main = reg_wr && (reg_addr == A_MAIN);
    assign wr_aux1 = reg_wr && (reg_addr == A_AUX1);
    assign wr_aux2 = reg_wr && (reg_addr == A_AUX2);
    assign wr_mask = reg_wr && (reg_addr == A_MASK);

    always_comb begin
        evt_set     = '0;
        evt_set[8]  = init_done;
        evt_set[9]  = ev_tx;
        evt_set[10] = ev_rx;
        evt_set[11] = ev_merr;
        evt_set[12] = ev_miss;
        evt_set[14] = ev_babl;
    end

    assign uconv = aux1_q[UREQ_BIT] && int_en;

    always_comb begin
        aux1_set = '0;
        aux1_clr = '0;
        for (int k = 0; k < N_AUX1_EVT; k++)
            aux1_set[AUX1_EVT_POS[k]] = ev_aux1[k];
        aux1_set[USTAT_BIT] = uconv;
        aux1_clr[UREQ_BIT]  = uconv;
        aux2_set = '0;
        aux2_set[AUX2_EVT_POS] = ev_aux2;
    end

    isr_ctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (wr_main && reg_wdata[1]),
        .stop_req  (wr_main && reg_wdata[2]),
        .init_done (init_done),
        .tx_off    (tx_off),
        .rx_off    (rx_off),
        .ctl       (ctl)
    );

    isr_flag_reg #(.W(DW), .W1C_MASK(MAIN_EVT_BITS)) u_main_evt (
        .clk(clk), .rst_n(rst_n), .wr(wr_main),
        .wdata(reg_wdata & MAIN_EVT_BITS),
        .hw_set(evt_set), .hw_clr('0), .q(evt_q)
    );

    isr_flag_reg #(.W(DW), .W1C_MASK(AUX1_W1C)) u_aux1 (
        .clk(clk), .rst_n(rst_n), .wr(wr_aux1), .wdata(reg_wdata),
        .hw_set(aux1_set), .hw_clr(aux1_clr), .q(aux1_q)
    );

    isr_flag_reg #(.W(DW), .W1C_MASK(AUX2_W1C)) u_aux2 (
        .clk(clk), .rst_n(rst_n), .wr(wr_aux2), .wdata(reg_wdata),
        .hw_set(aux2_set), .hw_clr('0), .q(aux2_q)
    );

    isr_flag_reg #(.W(DW), .W1C_MASK('0)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr(wr_mask), .wdata(reg_wdata),
        .hw_set('0), .hw_clr('0), .q(mask_q)
    );

    isr_summary u_sum (
        .main_evt (evt_q),
        .mask     (mask_q),
        .aux1     (aux1_q),
        .aux2     (aux2_q),
        .summary  (summary)
    );

    always_comb begin
        unique case (reg_addr)
            A_MAIN:  reg_rdata = evt_q | {10'd0, ctl} | (DW'(summary) << SUM_BIT);
            A_AUX1:  reg_rdata = aux1_q;
            A_AUX2:  reg_rdata = aux2_q;
            default: reg_rdata = mask_q;
        endcase
    end

    assign intr = summary & int_en;

    AST_UREQ_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (aux1_q[UREQ_BIT] && int_en && !wr_aux1) |=> (aux1_q[USTAT_BIT] && !aux1_q[UREQ_BIT])); // R7
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q == '0 && aux1_q == '0 && aux2_q == '0) |-> !intr); // R6
endmodule

// File: tb/isr_aggregator_bench.sv
module isr_aggregator_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic        reg_wr = 0;
    logic        int_en = 0, tx_off = 0, rx_off = 0;
    logic        init_done = 0, ev_tx = 0, ev_rx = 0, ev_merr = 0, ev_miss = 0, ev_babl = 0;
    logic [3:0]  ev_aux1 = 0;
    logic        ev_aux2 = 0;
    logic [15:0] reg_rdata;
    logic        intr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isr_aggregator u_isr_aggregator (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .int_en(int_en), .tx_off(tx_off), .rx_off(rx_off),
        .init_done(init_done), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_merr(ev_merr),
        .ev_miss(ev_miss), .ev_babl(ev_babl), .ev_aux1(ev_aux1), .ev_aux2(ev_aux2),
        .reg_rdata(reg_rdata), .intr(intr)
    );

    // {wr, addr, wdata, int_en, read addr, expected read, expected intr}
    localparam logic [38:0] TBL [10] = '{
        {1'b1, 2'd3, 16'h1234, 1'b0, 2'd3, 16'h1234, 1'b0}, // R8 mask plain
        {1'b1, 2'd3, 16'h0000, 1'b0, 2'd3, 16'h0000, 1'b0}, // R8
        {1'b1, 2'd1, 16'h0002, 1'b0, 2'd1, 16'h0000, 1'b0}, // R8 w1c cannot set
        {1'b1, 2'd1, 16'h0015, 1'b0, 2'd1, 16'h0015, 1'b0}, // R8 plain bits
        {1'b1, 2'd2, 16'h0008, 1'b0, 2'd2, 16'h0008, 1'b0}, // R5 half pair
        {1'b1, 2'd1, 16'h0080, 1'b0, 2'd1, 16'h0080, 1'b0}, // R7 held while disabled
        {1'b0, 2'd0, 16'h0000, 1'b1, 2'd1, 16'h0040, 1'b0}, // R7 conversion
        {1'b1, 2'd1, 16'h0040, 1'b1, 2'd1, 16'h0000, 1'b0}, // R8 clear bit 6
        {1'b1, 2'd0, 16'h0002, 1'b1, 2'd0, 16'h0032, 1'b0}, // R10 start
        {1'b1, 2'd0, 16'h0004, 1'b1, 2'd0, 16'h0004, 1'b0}  // R11 stop
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [15:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic summary_line();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary_line();
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            reg_wr = TBL[i][38]; reg_addr = TBL[i][37:36];
            reg_wdata = TBL[i][35:20]; int_en = TBL[i][19];
            @(negedge clk);
            reg_wr = 0;
            rd(TBL[i][18:17], $sformatf("table step %0d", i), TBL[i][16:1]);
            chk($sformatf("table step %0d intr R6", i), {15'd0, intr}, {15'd0, TBL[i][0]});
        end

        // R1 reset state
        int_en = 0;
        do_reset();
        rd(2'd0, "R1 main", 16'h0004);
        rd(2'd1, "R1 aux1", 16'h0000);
        rd(2'd2, "R1 aux2", 16'h0000);
        rd(2'd3, "R1 mask", 16'h0000);
        chk("R1 intr", {15'd0, intr}, 16'h0);
        int_en = 1;

        // R2 R3 R6 main events and masking
        @(negedge clk); ev_rx = 1; @(negedge clk); ev_rx = 0;
        rd(2'd0, "R2 R3 rx event", 16'h0484);
        chk("R6 intr on", {15'd0, intr}, 16'h1);
        wr(2'd3, 16'h0400);
        rd(2'd0, "R3 masked", 16'h0404);
        chk("R3 R6 intr masked", {15'd0, intr}, 16'h0);
        wr(2'd0, 16'h0400);
        rd(2'd0, "R2 w1c", 16'h0004);
        wr(2'd3, 16'h0000);

        // R12 event beats clear
        @(negedge clk); reg_wr = 1; reg_addr = 2'd0; reg_wdata = 16'h0200; ev_tx = 1;
        @(negedge clk); reg_wr = 0; ev_tx = 0;
        rd(2'd0, "R12 event wins", 16'h0284);
        wr(2'd0, 16'h0200);
        rd(2'd0, "R2 tx cleared", 16'h0004);

        // R4 aux1 pairs
        @(negedge clk); ev_aux1 = 4'b0001; @(negedge clk); ev_aux1 = 0;
        rd(2'd1, "R4 aux1 event", 16'h0002);
        chk("R4 intr", {15'd0, intr}, 16'h1);
        wr(2'd1, 16'h0001);
        rd(2'd1, "R4 paired mask", 16'h0003);
        chk("R4 intr masked", {15'd0, intr}, 16'h0);
        wr(2'd1, 16'h0002);
        rd(2'd1, "R8 aux1 clear", 16'h0000);
        @(negedge clk); ev_aux1 = 4'b1000; @(negedge clk); ev_aux1 = 0;
        rd(2'd1, "R4 bit9 event", 16'h0200);
        chk("R4 bit9 intr", {15'd0, intr}, 16'h1);
        wr(2'd1, 16'h0200);
        rd(2'd1, "R8 bit9 clear", 16'h0000);

        // R5 aux2 pair
        wr(2'd2, 16'h0008);
        @(negedge clk); ev_aux2 = 1; @(negedge clk); ev_aux2 = 0;
        rd(2'd2, "R5 aux2 both", 16'h0018);
        chk("R5 intr", {15'd0, intr}, 16'h1);
        wr(2'd2, 16'h0018);
        rd(2'd2, "R8 aux2 w1c", 16'h0008);
        chk("R5 intr off", {15'd0, intr}, 16'h0);
        wr(2'd2, 16'h0080);
        rd(2'd2, "R8 aux2 bit7", 16'h0000);

        // R9 R10 R11 run-state sequence
        @(negedge clk); init_done = 1; @(negedge clk); init_done = 0;
        rd(2'd0, "R9 init done", 16'h0181);
        tx_off = 1;
        wr(2'd0, 16'h0002);
        rd(2'd0, "R10 start tx off", 16'h01A3);
        tx_off = 0;
        wr(2'd0, 16'h0002);
        rd(2'd0, "R10 restart ignored", 16'h01A3);
        wr(2'd0, 16'h0006);
        rd(2'd0, "R11 stop", 16'h0184);
        wr(2'd0, 16'h0100);
        rd(2'd0, "R2 idon clear", 16'h0004);

        done = 1;
        summary_line();
        $finish;
    end
endmodule